// File: doc/BRIEF.md
# Alternating Sync Rate Meter

This block measures the line and field rates of an incoming video signal with a single 10-bit up counter that is shared between two measurements. After reset it measures the field (vertical) period. It counts ticks of a 31.25 kHz time base between two consecutive VSYNC rising edges. When software reads the result, the block switches to the line (horizontal) rate. It counts HSYNC rising edges during a fixed window of ticks. When that result is read, it returns to the vertical measurement. Turning a count into a frequency is left to software.

A finished measurement raises a ready flag and, if enabled, an interrupt request. The counter and the flags then hold still until software reads the count register. Very slow field rates are handled by a two-stage overflow record. The first wrap of the counter is noted and counting continues. A second wrap ends the measurement. The time base is a single-cycle enable that a divider derives from the system clock. Both sync inputs are already polarity-normalized and are captured through two flip-flops before their rising edges are detected.

Top module: `sync_rate_meter`

## Requirements
- R1: After reset, ready, interrupt, mode flag (0 = vertical), both overflow flags and both register outputs are 0, and the block waits for a VSYNC rising edge.
- R2: In vertical mode the count is the number of time-base ticks (one every TICK_DIV system clocks) strictly between the cycle that sees one VSYNC rising edge and the cycle that sees the next. A tick in the same cycle as the closing edge is not counted. The closing edge sets ready.
- R3: While ready is 1 and no count-register read occurs, the count, mode flag, overflow flags and ready stay unchanged, whatever the sync inputs do.
- R4: A count-register read while ready is 1 in vertical mode clears ready, the interrupt, the count and both overflow flags, sets the mode flag to 1, and starts a horizontal window.
- R5: In horizontal mode the count is the number of HSYNC rising edges seen during a window of WIN_TICKS time-base ticks that starts at the accepting read. VSYNC edges are ignored. The window's end sets ready.
- R6: A count-register read while ready is 1 in horizontal mode clears ready, the interrupt, the count, both overflow flags and the mode flag, and re-arms the vertical measurement.
- R7: The interrupt output rises together with ready when the interrupt-enable input is 1 in the cycle that completes the measurement. It stays 0 when that input is 0, and it is cleared by the accepting read.
- R8: The first counter wrap from 1023 to 0 sets the once-overflow flag and counting goes on. The second wrap clears it, sets the twice-overflow flag and ready, and leaves the count at 0. Both flags are never 1 together.
- R9: The count register output carries count bits 9..2. The status register output carries the mode flag in bit 7, the twice-overflow flag in bit 3, the once-overflow flag in bit 2 and count bits 1..0 in bits 1..0. Bits 6..4 are 0.
- R10: A count-register read while ready is 0 changes neither the mode nor the measurement in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Polarity-normalized line sync, asynchronous |
| vsync_in | input | 1 | Polarity-normalized field sync, asynchronous |
| irq_en | input | 1 | Interrupt enable |
| rd_count | input | 1 | One-cycle strobe: count register is being read |
| count_reg | output | 8 | Count bits 9..2 |
| status_reg | output | 8 | Mode, overflow flags and count bits 1..0 |
| rdy | output | 1 | Measurement complete |
| hv_mode | output | 1 | 0 = vertical, 1 = horizontal |
| ovf_once | output | 1 | Counter has wrapped once |
| ovf_twice | output | 1 | Counter has wrapped twice |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with TICK_DIV = 4 and WIN_TICKS = 16, so a tick arrives every four system clocks and a horizontal window lasts 64 cycles. With these values a second counter wrap, which takes 2048 ticks, is reached in about 8200 cycles, so both overflow stages and the frozen state after them are tested. VSYNC edges are spaced 4k+1 cycles apart. With that spacing the vertical count is exactly k whatever the divider phase. The short window lets HSYNC bursts of 0 to 20 pulses fit inside one window.

// File: rtl/srm_pkg.sv
package srm_pkg;

    localparam int CNT_W     = 10;
    localparam int CNT_REG_W = CNT_W - 2;

    typedef enum logic [1:0] {
        ST_VARM = 2'd0,
        ST_VRUN = 2'd1,
        ST_HRUN = 2'd2,
        ST_HOLD = 2'd3
    } meas_st_e;

    typedef struct packed {
        logic hv;
        logic ovf2;
        logic ovf1;
    } meas_flags_t;

    function automatic logic [7:0] pack_status(meas_flags_t f, logic [1:0] cnt_lsb);
        return {f.hv, 3'b000, f.ovf2, f.ovf1, cnt_lsb};
    endfunction

endpackage

// File: rtl/srm_tick_gen.sv
module srm_tick_gen #(
    parameter int DIV = 384
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = (div_q == LAST);
endmodule

// File: rtl/srm_rise_det.sv
module srm_rise_det (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [2:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[1:0], din};
        end
    end

    assign rise = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/srm_meas_core.sv
module srm_meas_core
    import srm_pkg::*;
#(
    parameter int WIN_TICKS = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             v_rise,
    input  logic             h_rise,
    input  logic             irq_en,
    input  logic             rd_count,
    output logic [CNT_W-1:0] count,
    output logic             ready,
    output meas_flags_t      flags,
    output logic             irq
);
    localparam int WIN_W = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_TICKS - 1);

    meas_st_e         st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    meas_flags_t      flg_q, flg_d;
    logic [WIN_W-1:0] win_q, win_d;
    logic             irq_q, irq_d;
    logic             bump, finish;
    logic [CNT_W:0]   sum;

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        flg_d  = flg_q;
        win_d  = win_q;
        irq_d  = irq_q;
        bump   = 1'b0;
        finish = 1'b0;
        sum    = '0;

        unique case (st_q)
            ST_VARM: begin
                if (v_rise) st_d = ST_VRUN;
            end
            ST_VRUN: begin
                // closing edge wins over a coincident tick
                if (v_rise) finish = 1'b1;
                else        bump   = tick;
            end
            ST_HRUN: begin
                bump = h_rise;
                if (tick) begin
                    win_d = win_q + 1'b1;
                    if (win_q == WIN_LAST) finish = 1'b1;
                end
            end
            ST_HOLD: begin
                if (rd_count) begin
                    cnt_d      = '0;
                    flg_d.ovf1 = 1'b0;
                    flg_d.ovf2 = 1'b0;
                    irq_d      = 1'b0;
                    win_d      = '0;
                    if (flg_q.hv) begin
                        flg_d.hv = 1'b0;
                        st_d     = ST_VARM;
                    end else begin
                        flg_d.hv = 1'b1;
                        st_d     = ST_HRUN;
                    end
                end
            end
            default: st_d = ST_VARM;
        endcase

        if (bump) begin
            sum   = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
            cnt_d = sum[CNT_W-1:0];
            if (sum[CNT_W]) begin
                if (flg_q.ovf1) begin
                    flg_d.ovf1 = 1'b0;
                    flg_d.ovf2 = 1'b1;
                    finish     = 1'b1;
                end else begin
                    flg_d.ovf1 = 1'b1;
                end
            end
        end

        if (finish) begin
            st_d  = ST_HOLD;
            irq_d = irq_en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_VARM;
            cnt_q <= '0;
            flg_q <= '0;
            win_q <= '0;
            irq_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            flg_q <= flg_d;
            win_q <= win_d;
            irq_q <= irq_d;
        end
    end

    assign count = cnt_q;
    assign ready = (st_q == ST_HOLD);
    assign flags = flg_q;
    assign irq   = irq_q;
endmodule

// File: rtl/sync_rate_meter.sv
module sync_rate_meter
    import srm_pkg::*;
#(
    parameter int TICK_DIV  = 384,
    parameter int WIN_TICKS = 256
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hsync_in,
    input  logic                 vsync_in,
    input  logic                 irq_en,
    input  logic                 rd_count,
    output logic [CNT_REG_W-1:0] count_reg,
    output logic [7:0]           status_reg,
    output logic                 rdy,
    output logic                 hv_mode,
    output logic                 ovf_once,
    output logic                 ovf_twice,
    output logic                 irq
);
    logic             tick;
    logic [1:0]       sync_raw;
    logic [1:0]       sync_rise;
    logic [CNT_W-1:0] count;
    meas_flags_t      flags;

    srm_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    assign sync_raw = {vsync_in, hsync_in};

    for (genvar g = 0; g < 2; g++) begin : g_edge
        srm_rise_det u_det (
            .clk  (clk),
            .rst  (rst),
            .din  (sync_raw[g]),
            .rise (sync_rise[g])
        );
    end

    srm_meas_core #(.WIN_TICKS(WIN_TICKS)) u_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .v_rise   (sync_rise[1]),
        .h_rise   (sync_rise[0]),
        .irq_en   (irq_en),
        .rd_count (rd_count),
        .count    (count),
        .ready    (rdy),
        .flags    (flags),
        .irq      (irq)
    );

    assign count_reg  = count[CNT_W-1:2];
    assign status_reg = pack_status(flags, count[1:0]);
    assign hv_mode    = flags.hv;
    assign ovf_once   = flags.ovf1;
    assign ovf_twice  = flags.ovf2;
endmodule

// File: rtl/srm_checker.sv
module srm_checker (
    input logic       clk,
    input logic       rst,
    input logic       irq_en,
    input logic       rd_count,
    input logic [7:0] count_reg,
    input logic [7:0] status_reg,
    input logic       rdy,
    input logic       hv_mode,
    input logic       ovf_once,
    input logic       ovf_twice,
    input logic       irq
);
    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (!rdy && !hv_mode && !irq && !ovf_once && !ovf_twice));

    p_no_double_ovf_r8: assert property (@(posedge clk) disable iff (rst)
        !(ovf_once && ovf_twice));

    p_twice_ends_r8: assert property (@(posedge clk) disable iff (rst)
        ovf_twice |-> rdy);

    p_hold_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        (rdy && !rd_count) |=> (rdy && $stable(count_reg) && $stable(status_reg)));

    p_vread_switch_r4: assert property (@(posedge clk) disable iff (rst)
        (rdy && rd_count && !hv_mode) |=>
            (!rdy && hv_mode && !irq && count_reg == 8'd0 && status_reg[3:0] == 4'd0));

    p_hread_switch_r6: assert property (@(posedge clk) disable iff (rst)
        (rdy && rd_count && hv_mode) |=> (!rdy && !hv_mode && !irq && count_reg == 8'd0));

    p_idle_read_r10: assert property (@(posedge clk) disable iff (rst)
        (!rdy && rd_count) |=> (hv_mode == $past(hv_mode)));

    p_irq_needs_rdy_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> rdy);

    p_irq_on_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy) |-> (irq == $past(irq_en)));

    p_status_pad_r9: assert property (@(posedge clk) disable iff (rst)
        status_reg[6:4] == 3'b000);
endmodule

bind sync_rate_meter srm_checker u_srm_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_en     (irq_en),
    .rd_count   (rd_count),
    .count_reg  (count_reg),
    .status_reg (status_reg),
    .rdy        (rdy),
    .hv_mode    (hv_mode),
    .ovf_once   (ovf_once),
    .ovf_twice  (ovf_twice),
    .irq        (irq)
);

// File: tb/test_sync_rate_meter.sv
module test_sync_rate_meter;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int WIN        = 16;
    localparam int NVEC       = 5;
    localparam int VEC_K   [NVEC] = '{3, 10, 37, 1, 200};
    localparam int VEC_N   [NVEC] = '{5, 0, 12, 20, 1};
    localparam int VEC_IEN [NVEC] = '{1, 0, 1, 0, 1};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hs = 1'b0, vs = 1'b0, ien = 1'b0, rd = 1'b0;
    logic [7:0] count_reg, status_reg;
    logic       rdy, hv_mode, ovf_once, ovf_twice, irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_rate_meter #(.TICK_DIV(DIV), .WIN_TICKS(WIN)) i_sync_rate_meter (
        .clk        (clk),
        .rst        (rst),
        .hsync_in   (hs),
        .vsync_in   (vs),
        .irq_en     (ien),
        .rd_count   (rd),
        .count_reg  (count_reg),
        .status_reg (status_reg),
        .rdy        (rdy),
        .hv_mode    (hv_mode),
        .ovf_once   (ovf_once),
        .ovf_twice  (ovf_twice),
        .irq        (irq)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle(int c);
        repeat (c) @(negedge clk);
    endtask

    task automatic vpulse();
        vs = 1'b1; @(negedge clk); @(negedge clk); vs = 1'b0;
    endtask

    task automatic hpulse();
        hs = 1'b1; @(negedge clk); hs = 1'b0; @(negedge clk);
    endtask

    // two VSYNC rises DIV*k+1 cycles apart give exactly k ticks
    task automatic vmeasure(int k);
        vpulse();
        idle(DIV*k + 1 - 2);
        vpulse();
    endtask

    task automatic wait_rdy(string req, int lim);
        int i = 0;
        while (!rdy && i < lim) begin
            @(negedge clk);
            i++;
        end
        chk(req, "rdy", int'(rdy), 1);
    endtask

    task automatic do_read();
        rd = 1'b1; @(negedge clk); rd = 1'b0;
    endtask

    task automatic check_regs(string req, int hv, int o2, int o1, int cnt);
        chk(req, "count_reg", int'(count_reg), cnt >> 2);
        chk(req, "status_reg", int'(status_reg), hv*128 + o2*8 + o1*4 + (cnt & 3));
    endtask

    initial begin
        idle(4);
        rst = 1'b0;
        idle(1);
        // R1 reset state
        chk("R1", "rdy", int'(rdy), 0);
        chk("R1", "hv_mode", int'(hv_mode), 0);
        chk("R1", "irq", int'(irq), 0);
        check_regs("R1", 0, 0, 0, 0);

        // R10 read while not ready, both idle and mid-measurement
        do_read();
        chk("R10", "hv_mode idle read", int'(hv_mode), 0);
        chk("R10", "rdy idle read", int'(rdy), 0);
        vpulse();
        idle(10);
        do_read();
        idle(DIV*6 + 1 - 2 - 10 - 1);
        vpulse();
        wait_rdy("R10", 200);
        check_regs("R10", 0, 0, 0, 6);
        do_read();
        chk("R4", "hv_mode after read", int'(hv_mode), 1);
        wait_rdy("R5", WIN*DIV*2);
        check_regs("R5", 1, 0, 0, 0);
        do_read();
        chk("R6", "hv_mode after read", int'(hv_mode), 0);

        // vector table: vertical period then horizontal burst
        for (int i = 0; i < NVEC; i++) begin
            ien = VEC_IEN[i][0];
            vmeasure(VEC_K[i]);
            wait_rdy("R2", 200);
            check_regs("R2 R9", 0, 0, 0, VEC_K[i]);
            chk("R7", "irq vertical", int'(irq), VEC_IEN[i]);
            do_read();
            chk("R4", "hv_mode", int'(hv_mode), 1);
            chk("R4", "rdy", int'(rdy), 0);
            chk("R4", "irq cleared", int'(irq), 0);
            check_regs("R4", 1, 0, 0, 0);
            for (int j = 0; j < VEC_N[i]; j++) begin
                hpulse();
                if (j == 1) vpulse();   // R5: VSYNC ignored in horizontal mode
            end
            wait_rdy("R5", WIN*DIV*2);
            check_regs("R5 R9", 1, 0, 0, VEC_N[i]);
            chk("R7", "irq horizontal", int'(irq), VEC_IEN[i]);
            do_read();
            chk("R6", "hv_mode", int'(hv_mode), 0);
            chk("R6", "rdy", int'(rdy), 0);
            chk("R6", "irq cleared", int'(irq), 0);
        end

        // R8 single overflow: 1029 ticks -> count 5 with once flag
        ien = 1'b1;
        vmeasure(1029);
        wait_rdy("R8", 200);
        check_regs("R8 once", 0, 0, 1, 5);
        chk("R8", "ovf_once", int'(ovf_once), 1);
        chk("R7", "irq", int'(irq), 1);
        // R3 frozen while ready
        idle(40);
        vpulse();
        hpulse();
        idle(5);
        check_regs("R3", 0, 0, 1, 5);
        chk("R3", "rdy", int'(rdy), 1);
        do_read();
        check_regs("R4 ovf cleared", 1, 0, 0, 0);
        repeat (3) hpulse();
        wait_rdy("R5", WIN*DIV*2);
        check_regs("R5", 1, 0, 0, 3);
        do_read();

        // R8 double overflow: single VSYNC, 2048 ticks end it
        ien = 1'b0;
        vpulse();
        wait_rdy("R8", 2048*DIV + 200);
        check_regs("R8 twice", 0, 1, 0, 0);
        chk("R8", "ovf_twice", int'(ovf_twice), 1);
        chk("R7", "irq disabled", int'(irq), 0);
        vpulse();
        idle(5);
        check_regs("R3 after twice", 0, 1, 0, 0);
        do_read();
        chk("R4", "hv_mode", int'(hv_mode), 1);
        check_regs("R4 twice cleared", 1, 0, 0, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule